// File: doc/BRIEF.md
# Staged Pipeline Control Register Chain

This block generates and carries the control bits of a five-stage in-order pipeline. A small opcode decoder in the decode stage produces every control setting at once. The settings then move through three registers, one after each of decode, execute and memory. Each stage picks off only its own group of bits, and the remaining bits move on to the next stage.

The ALU-side group (operand source, operation code, destination-name select) is used in execute. The memory group (read, write, branch) is used one stage later. The writeback group (result source, register write enable) is used in the last stage. Fetch and decode need no instruction-dependent control. The block only gives fetch an enable that drops when the pipe is held or a bubble is being inserted.

A bubble request replaces the decoded word entering execute with all zeros, so that slot changes no state. A global stall freezes all three registers.

Top module: `ctl_chain_pipe`

## Requirements
- R1: Opcode 6'b000000 (register-register) decodes to alu_src=0, alu_op=2'b10, dst_sel=1, mem_rd=0, mem_wr=0, branch=0, wb_from_mem=0, wb_reg_we=1.
- R2: Opcode 6'b100011 (load) decodes to alu_src=1, alu_op=2'b00, dst_sel=0, mem_rd=1, mem_wr=0, branch=0, wb_from_mem=1, wb_reg_we=1.
- R3: Opcode 6'b101011 (store) decodes to alu_src=1, alu_op=2'b00, dst_sel=0, mem_rd=0, mem_wr=1, branch=0, wb_from_mem=0, wb_reg_we=0.
- R4: Opcode 6'b000100 (branch-equal) decodes to alu_src=0, alu_op=2'b01, dst_sel=0, mem_rd=0, mem_wr=0, branch=1, wb_from_mem=0, wb_reg_we=0.
- R5: Any other opcode decodes to an all-zero control word.
- R6: The control groups of an opcode presented at a clock edge with no stall appear at the execute outputs after that edge. They appear at the memory outputs one edge later and at the writeback outputs two edges later.
- R7: A bubble request at an edge with no stall loads an all-zero word into the execute stage, whatever the opcode is.
- R8: A stall at an edge holds all three stage registers unchanged, and fetch_en is 0 while stall is 1.
- R9: fetch_en is 1 when neither stall nor bubble is asserted, and 0 while bubble is asserted.
- R10: While rst_n is low, all stage control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 6 | Opcode of the instruction in decode |
| bubble | input | 1 | Insert an all-zero slot into execute |
| stall | input | 1 | Hold every stage register |
| fetch_en | output | 1 | Instruction read and PC increment enable |
| ex_alu_src | output | 1 | ALU second operand: 1 immediate, 0 register |
| ex_alu_op | output | 2 | ALU operation class |
| ex_dst_sel | output | 1 | Destination name: 1 rd field, 0 rt field |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| mem_branch | output | 1 | Branch-on-equal control |
| wb_from_mem | output | 1 | Write-back value: 1 memory data, 0 ALU result |
| wb_reg_we | output | 1 | Register file write enable |

## Verification
The assertions check on every cycle that:
- a stall freezes every output group and keeps fetch disabled;
- a bubble leaves an all-zero execute group;
- at most one memory action is active;
- memory-data write-back never comes without a write enable.

Only the bench's scenarios can show that each opcode yields its exact word. The same goes for the groups of one instruction arriving at the correct later stages, across mixed streams with bubbles and stalls. The bench checks this against its own delayed model.

// File: rtl/ctl_chain_pipe.sv
module ctl_chain_pipe #(
  parameter int OPW = 6,
  parameter int AOPW = 2,
  parameter logic [OPW-1:0] OP_RR = 6'b000000,
  parameter logic [OPW-1:0] OP_LD = 6'b100011,
  parameter logic [OPW-1:0] OP_ST = 6'b101011,
  parameter logic [OPW-1:0] OP_BEQ = 6'b000100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  opcode,
  input  logic            bubble,
  input  logic            stall,
  output logic            fetch_en,
  output logic            ex_alu_src,
  output logic [AOPW-1:0] ex_alu_op,
  output logic            ex_dst_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_branch,
  output logic            wb_from_mem,
  output logic            wb_reg_we
);
  localparam int WBW = 2;
  localparam int MEW = 3;
  localparam int EXW = AOPW + 2;
  localparam int W1 = EXW + MEW + WBW;
  localparam int W2 = MEW + WBW;

  logic [W1-1:0]  dec_w, idex_q;
  logic [W2-1:0]  exmem_q;
  logic [WBW-1:0] memwb_q;

  always_comb begin
    dec_w = '0;
    case (opcode)
      OP_RR:  dec_w = {1'b0, AOPW'(2), 1'b1, 3'b000, 2'b01};
      OP_LD:  dec_w = {1'b1, AOPW'(0), 1'b0, 3'b100, 2'b11};
      OP_ST:  dec_w = {1'b1, AOPW'(0), 1'b0, 3'b010, 2'b00};
      OP_BEQ: dec_w = {1'b0, AOPW'(1), 1'b0, 3'b001, 2'b00};
      default: dec_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else if (!stall) begin
      idex_q  <= bubble ? '0 : dec_w;
      exmem_q <= idex_q[W2-1:0];
      memwb_q <= exmem_q[WBW-1:0];
    end
  end

  assign fetch_en = !(stall || bubble);
  assign {ex_alu_src, ex_alu_op, ex_dst_sel} = idex_q[W1-1:W2];
  assign {mem_rd, mem_wr, mem_branch} = exmem_q[W2-1:WBW];
  assign {wb_from_mem, wb_reg_we} = memwb_q;
endmodule

module ctl_chain_pipe_chk #(parameter int AOPW = 2) (
  input logic            clk,
  input logic            rst_n,
  input logic            bubble,
  input logic            stall,
  input logic            fetch_en,
  input logic            ex_alu_src,
  input logic [AOPW-1:0] ex_alu_op,
  input logic            ex_dst_sel,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            mem_branch,
  input logic            wb_from_mem,
  input logic            wb_reg_we
);
  logic [AOPW+1:0] ex_g;
  logic [2:0] me_g;
  logic [1:0] wb_g;
  assign ex_g = {ex_alu_src, ex_alu_op, ex_dst_sel};
  assign me_g = {mem_rd, mem_wr, mem_branch};
  assign wb_g = {wb_from_mem, wb_reg_we};

  // R7
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble && !stall) |=> (ex_g == '0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(ex_g) && $stable(me_g) && $stable(wb_g)));
  // R8
  stall_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !fetch_en);
  // R1
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(me_g));
  // R2
  wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_from_mem |-> wb_reg_we);
endmodule

bind ctl_chain_pipe ctl_chain_pipe_chk #(.AOPW(AOPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bubble(bubble), .stall(stall),
  .fetch_en(fetch_en), .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op),
  .ex_dst_sel(ex_dst_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_branch(mem_branch), .wb_from_mem(wb_from_mem), .wb_reg_we(wb_reg_we)
);

// File: tb/sim_ctl_chain_pipe.sv
module sim_ctl_chain_pipe;
  logic clk = 0, rst_n = 0, bubble = 0, stall = 0;
  logic [5:0] opcode = '0;
  logic fetch_en, ex_alu_src, ex_dst_sel, mem_rd, mem_wr, mem_branch, wb_from_mem, wb_reg_we;
  logic [1:0] ex_alu_op;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [8:0] m1, m2, m3;

  always #2 clk = ~clk;

  ctl_chain_pipe u0 (.clk(clk), .rst_n(rst_n), .opcode(opcode), .bubble(bubble),
    .stall(stall), .fetch_en(fetch_en), .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op),
    .ex_dst_sel(ex_dst_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_branch(mem_branch),
    .wb_from_mem(wb_from_mem), .wb_reg_we(wb_reg_we));

  // word: {alu_src, alu_op[1:0], dst_sel, rd, wr, br, wb_mem, wb_we}
  function automatic logic [8:0] dec(input logic [5:0] op);
    case (op)
      6'b000000: return 9'b0_10_1_000_01; // R1
      6'b100011: return 9'b1_00_0_100_11; // R2
      6'b101011: return 9'b1_00_0_010_00; // R3
      6'b000100: return 9'b0_01_0_001_00; // R4
      default:   return 9'b0;             // R5
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m1 <= '0; m2 <= '0; m3 <= '0; end
    else if (!stall) begin m1 <= bubble ? 9'b0 : dec(opcode); m2 <= m1; m3 <= m2; end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ex_w(); return {ex_alu_src, ex_alu_op, ex_dst_sel, 5'b0}; endfunction
  function automatic logic [8:0] me_w(); return {4'b0, mem_rd, mem_wr, mem_branch, 2'b0}; endfunction
  function automatic logic [8:0] wb_w(); return {7'b0, wb_from_mem, wb_reg_we}; endfunction

  task automatic full_chk(input string req);
    chk(req, ex_w(), {m1[8:5], 5'b0});
    chk(req, me_w(), {4'b0, m2[4:2], 2'b0});
    chk(req, wb_w(), {7'b0, m3[1:0]});
    chk("R9", {8'b0, fetch_en}, {8'b0, !(stall || bubble)});
  endtask

  task automatic step(input logic [5:0] op, input logic b, input logic s, input string req);
    opcode = op; bubble = b; stall = s;
    @(negedge clk);
    full_chk(req);
  endtask

  initial begin
    void'($urandom(32'd2024));
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    chk("R10", ex_w() | me_w() | wb_w(), 9'b0);
    rst_n = 1;
    @(negedge clk);
    // directed decode checks, ex group one edge later
    step(6'b000000, 0, 0, "R1"); chk("R1", ex_w(), 9'b0_10_1_00000);
    step(6'b100011, 0, 0, "R2"); chk("R2", ex_w(), 9'b1_00_0_00000);
    step(6'b101011, 0, 0, "R3"); chk("R3", ex_w(), 9'b1_00_0_00000);
    chk("R6", me_w(), 9'b0000_100_00);
    chk("R6", wb_w(), 9'b0000000_01);
    step(6'b000100, 0, 0, "R4"); chk("R4", ex_w(), 9'b0_01_0_00000);
    chk("R6", me_w(), 9'b0000_010_00);
    chk("R6", wb_w(), 9'b0000000_11);
    step(6'b111111, 0, 0, "R5"); chk("R5", ex_w(), 9'b0);
    chk("R4", me_w(), 9'b0000_001_00);
    // load-use: load then bubble then consumer
    step(6'b100011, 0, 0, "R6");
    step(6'b000000, 1, 0, "R7"); chk("R7", ex_w(), 9'b0);
    chk("R9", {8'b0, fetch_en}, 9'b0);
    step(6'b000000, 0, 0, "R6");
    chk("R6", me_w(), 9'b0);
    step(6'b101011, 0, 1, "R8"); chk("R8", ex_w(), 9'b0_10_1_00000);
    chk("R8", {8'b0, fetch_en}, 9'b0);
    step(6'b101011, 1, 1, "R8"); chk("R8", ex_w(), 9'b0_10_1_00000);
    step(6'b101011, 0, 0, "R3");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      case ($urandom % 6)
        0: op = 6'b000000; 1: op = 6'b100011; 2: op = 6'b101011;
        3: op = 6'b000100; default: op = 6'($urandom);
      endcase
      step(op, ($urandom % 5) == 0, ($urandom % 6) == 0, "R6");
    end
    rst_n = 0;
    @(negedge clk);
    chk("R10", ex_w() | me_w() | wb_w(), 9'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule